// File: doc/BRIEF.md
# I2C Bus Hang Watchdog

This block sits beside the target-side protocol engine of an I2C/SMBus port and watches the two bus lines. The raw clock and data lines pass through two-flop synchronizers. A shared prescaler divides the system clock into a millisecond tick, gated by `tick_en`. Each line has its own low-time counter. If either line stays low for more than `LOW_LIMIT_TICKS` ticks, the block emits a one-cycle abort pulse to the engine. It then asserts `bus_release`, which forces the local line drivers off, until both lines read high again.

A second counter measures bus silence. Activity is a strobe from the protocol engine or any edge on either synchronized line. After `IDLE_LIMIT_TICKS` ticks of silence (five seconds by default, far longer than any legal SMBus timing), the block pulses a re-initialization request. It then holds `reinit_busy` for a short blanking window of `BLANK_CLKS` clocks, during which start conditions seen on the bus are not reported. Because both limits are counted in wall-clock ticks, the behaviour is the same whether the bus runs at 100 kHz (the power-up default) or 400 kHz.

The controller has five states:
- `GS_WATCH`: normal monitoring.
- `GS_ABORT`: one cycle, abort pulse.
- `GS_RELEASE`: drivers released while a line is low.
- `GS_REINIT`: one cycle, re-init pulse.
- `GS_BLANK`: start masking.

Its transitions are:
- WATCH→ABORT on a low-time expiry. This has priority over the idle expiry.
- WATCH→REINIT on an idle expiry.
- ABORT→RELEASE always.
- RELEASE→WATCH when both lines are high.
- REINIT→BLANK always.
- BLANK→ABORT on a low-time expiry.
- BLANK→WATCH after `BLANK_CLKS` cycles.

Top module: `i2c_hang_guard`

## Requirements
- R1: While and right after reset, `abort_pulse`, `bus_release`, `reinit_pulse`, `reinit_busy` and `start_seen` are all 0.
- R2: When the clock line is held low, `abort_pulse` rises for exactly one cycle. It does so more than `LOW_LIMIT_TICKS`×`CLKS_PER_TICK` clocks after the line went low, and no later than (`LOW_LIMIT_TICKS`+1)×`CLKS_PER_TICK`+6 clocks after.
- R3: The data line held low on its own, with the clock line high, produces the same abort within the same window.
- R4: A low period that ends before the limit produces no abort. The next low period counts again from zero.
- R5: `bus_release` is 1 in the cycle of the abort pulse. It falls within 4 clocks of both raw lines being high.
- R6: `bus_release` stays 1 while either line is still low.
- R7: After `IDLE_LIMIT_TICKS` ticks without activity, `reinit_pulse` is 1 for one cycle, within ((I−1)×P, I×P+8] clocks of the last activity, where I is `IDLE_LIMIT_TICKS` and P is `CLKS_PER_TICK`. The pulse repeats at the same interval for as long as the silence lasts.
- R8: A `bus_act` strobe, or any edge on either line, restarts the idle count, so activity spaced closer than the limit never causes a re-init.
- R9: `reinit_busy` is 1 for exactly `BLANK_CLKS`+1 consecutive cycles, starting in the cycle of `reinit_pulse`.
- R10: `start_seen` pulses once when the data line falls while the clock line is high. No pulse is given while `reinit_busy` is 1.
- R11: While `tick_en` is 0, neither timer advances, so a line held low gives no abort. Once `tick_en` returns to 1, the abort arrives within the R2 window, measured from that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_raw | input | 1 | Bus clock line level, asynchronous |
| sda_raw | input | 1 | Bus data line level, asynchronous |
| tick_en | input | 1 | Enables the millisecond prescaler |
| bus_act | input | 1 | Activity strobe from the protocol engine |
| abort_pulse | output | 1 | One-cycle request to drop the current transfer |
| bus_release | output | 1 | Forces the local line drivers off |
| reinit_pulse | output | 1 | One-cycle re-initialization request |
| reinit_busy | output | 1 | Re-init and blanking window active |
| start_seen | output | 1 | Start condition detected, masked while busy |

## Verification
Every internal state has a direct output, so a controller stuck in the wrong state shows up within one clock. A stuck `GS_RELEASE` keeps `bus_release` high after both lines rise, and a stuck `GS_BLANK` stretches `reinit_busy` beyond its fixed width. A low or idle counter that fails to clear or saturate only becomes visible as a pulse outside its timing window, up to one full limit later. So the bench times each abort and re-init against a computed window. It also holds lines low for just under the limit to expose counters that do not restart.

// File: rtl/hang_guard_pkg.sv
package hang_guard_pkg;

    typedef enum logic [2:0] {
        GS_WATCH   = 3'd0,
        GS_ABORT   = 3'd1,
        GS_RELEASE = 3'd2,
        GS_REINIT  = 3'd3,
        GS_BLANK   = 3'd4
    } guard_state_t;

    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Lines idle high, so reset to the released level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '1;
            stable_q <= '1;
        end else begin
            meta_q   <= d_i;
            stable_q <= meta_q;
        end
    end

    assign q_o = stable_q;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (en_i) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en_i)); // R11
endmodule

// File: rtl/line_low_timer.sv
module line_low_timer #(
    parameter int LIMIT = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int LW = $clog2(LIMIT + 2);
    localparam logic [LW-1:0] OVER = LW'(LIMIT + 1);

    logic [LW-1:0] cnt_q;

    // Counts ticks while the line is low; any high level restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (line_i || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != OVER)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == OVER);

    AST_LOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        line_i |=> !expired_o); // R4
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int IW = $clog2(LIMIT + 1);
    localparam logic [IW-1:0] TOP = IW'(LIMIT);

    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (act_i || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == TOP);

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> !expired_o); // R8
endmodule

// File: rtl/i2c_hang_guard.sv
module i2c_hang_guard
    import hang_guard_pkg::*;
#(
    parameter int CLKS_PER_TICK    = 50000,
    parameter int LOW_LIMIT_TICKS  = 35,
    parameter int IDLE_LIMIT_TICKS = 5000,
    parameter int BLANK_CLKS       = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    input  logic tick_en,
    input  logic bus_act,
    output logic abort_pulse,
    output logic bus_release,
    output logic reinit_pulse,
    output logic reinit_busy,
    output logic start_seen
);
    localparam int BW = (BLANK_CLKS > 2) ? $clog2(BLANK_CLKS) : 1;
    localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CLKS - 1);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] line_s;
    logic [NUM_LINES-1:0] line_q;
    logic [NUM_LINES-1:0] low_exp;
    logic                 scl_s, sda_s;
    logic                 line_edge, activity, tick;
    logic                 low_any, idle_exp, low_clr, idle_clr;
    logic                 sda_fall_scl_high;
    logic [BW-1:0]        blank_cnt_q;
    guard_state_t         state_q, state_d;

    assign raw_lines[LINE_SCL] = scl_raw;
    assign raw_lines[LINE_SDA] = sda_raw;

    line_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (line_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= line_s;
    end

    assign scl_s     = line_s[LINE_SCL];
    assign sda_s     = line_s[LINE_SDA];
    assign line_edge = |(line_s ^ line_q);
    assign activity  = bus_act | line_edge;

    tick_prescaler #(.DIV(CLKS_PER_TICK)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    // One low-time counter per bus line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_low
        line_low_timer #(.LIMIT(LOW_LIMIT_TICKS)) u_low (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (line_s[g]),
            .tick_i    (tick),
            .clr_i     (low_clr),
            .expired_o (low_exp[g])
        );
    end

    assign low_any = |low_exp;

    idle_timer #(.LIMIT(IDLE_LIMIT_TICKS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (activity),
        .tick_i    (tick),
        .clr_i     (idle_clr),
        .expired_o (idle_exp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_WATCH;
        else        state_q <= state_d;
    end

    // Blanking window length
    always_ff @(posedge clk) begin
        if (!rst_n)                  blank_cnt_q <= '0;
        else if (state_q == GS_BLANK) blank_cnt_q <= blank_cnt_q + 1'b1;
        else                         blank_cnt_q <= '0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_WATCH: begin
                if (low_any)       state_d = GS_ABORT;
                else if (idle_exp) state_d = GS_REINIT;
            end
            GS_ABORT:   state_d = GS_RELEASE;
            GS_RELEASE: if (scl_s && sda_s) state_d = GS_WATCH;
            GS_REINIT:  state_d = GS_BLANK;
            GS_BLANK: begin
                if (low_any)                         state_d = GS_ABORT;
                else if (blank_cnt_q == BLANK_LAST) state_d = GS_WATCH;
            end
            default:    state_d = GS_WATCH;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        abort_pulse  = 1'b0;
        bus_release  = 1'b0;
        reinit_pulse = 1'b0;
        reinit_busy  = 1'b0;
        low_clr      = 1'b0;
        idle_clr     = 1'b0;
        unique case (state_q)
            GS_WATCH: ;
            GS_ABORT: begin
                abort_pulse = 1'b1;
                bus_release = 1'b1;
                low_clr     = 1'b1;
            end
            GS_RELEASE: begin
                bus_release = 1'b1;
                low_clr     = 1'b1;
            end
            GS_REINIT: begin
                reinit_pulse = 1'b1;
                reinit_busy  = 1'b1;
                idle_clr     = 1'b1;
            end
            GS_BLANK:   reinit_busy = 1'b1;
            default: ;
        endcase
    end

    assign sda_fall_scl_high = line_q[LINE_SDA] && !sda_s && line_q[LINE_SCL] && scl_s;
    assign start_seen        = sda_fall_scl_high && !reinit_busy;

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R2
    AST_RELEASE_AT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> bus_release); // R5
    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_release && !(scl_s && sda_s)) |=> bus_release); // R6
    AST_REINIT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_pulse |=> (reinit_busy && !reinit_pulse)); // R9
    AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reinit_pulse, abort_pulse})); // R7
endmodule

// File: tb/i2c_hang_guard_tb.sv
module i2c_hang_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int L  = 35;
    localparam int I  = 300;
    localparam int B  = 64;
    localparam int K_ABORT  = 1;
    localparam int K_REINIT = 2;

    typedef struct {
        int    kind;
        int    lo;
        int    hi;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, scl_raw, sda_raw, tick_en, bus_act;
    logic abort_pulse, bus_release, reinit_pulse, reinit_busy, start_seen;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   n_abort = 0, n_reinit = 0, n_start = 0;
    int   last_act = 0;
    bit   keepalive;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_hang_guard #(
        .CLKS_PER_TICK(P), .LOW_LIMIT_TICKS(L),
        .IDLE_LIMIT_TICKS(I), .BLANK_CLKS(B)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .tick_en(tick_en), .bus_act(bus_act),
        .abort_pulse(abort_pulse), .bus_release(bus_release),
        .reinit_pulse(reinit_pulse), .reinit_busy(reinit_busy),
        .start_seen(start_seen)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    task automatic push_exp(input int kind, input int lo, input int hi, input string req);
        exp_t e;
        e.kind = kind; e.lo = lo; e.hi = hi; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic score(input int kind);
        exp_t e;
        checks++;
        if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL R4 R8: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
        end else begin
            e = sb_q.pop_front();
            if (e.kind != kind || cyc < e.lo || cyc > e.hi) begin
                errors++;
                $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d in [%0d,%0d]",
                         e.req, kind, cyc, e.kind, e.lo, e.hi);
            end
        end
    endtask

    // Monitor: compares produced events against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (abort_pulse === 1'b1) begin
                n_abort++;
                score(K_ABORT);
                chk("R5 release with abort", int'(bus_release), 1);
            end
            if (reinit_pulse === 1'b1) begin
                n_reinit++;
                score(K_REINIT);
            end
            if (start_seen === 1'b1) n_start++;
        end
    end

    // Activity keepalive strobe
    always @(negedge clk) begin
        if (rst_n === 1'b1 && keepalive && (cyc % 100) == 0) begin
            bus_act  = 1'b1;
            last_act = cyc;
        end else begin
            bus_act = 1'b0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_event(input int kind, input string req);
        int n = 0;
        @(negedge clk);
        while (((kind == K_ABORT) ? abort_pulse : reinit_pulse) !== 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
        if (n >= 5000) chk(req, 0, 1);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int a0, r0, s0, r1, w, k;
        rst_n = 1'b0; scl_raw = 1'b1; sda_raw = 1'b1; tick_en = 1'b1;
        bus_act = 1'b0; keepalive = 1'b1;
        wait_cyc(5);
        chk("R1 abort in reset",   int'(abort_pulse),  0);
        chk("R1 release in reset", int'(bus_release),  0);
        chk("R1 busy in reset",    int'(reinit_busy),  0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1 reinit after reset", int'(reinit_pulse), 0);
        chk("R1 start after reset",  int'(start_seen),   0);

        // R2, R5, R6: clock line stuck low
        scl_raw = 1'b0; k = cyc;
        push_exp(K_ABORT, k + L*P + 1, k + (L+1)*P + 6, "R2");
        wait_event(K_ABORT, "R2 abort missing");
        wait_cyc(100);
        chk("R5 release held while low", int'(bus_release), 1);
        sda_raw = 1'b0;
        wait_cyc(5);
        scl_raw = 1'b1;
        wait_cyc(20);
        chk("R6 release with data low", int'(bus_release), 1);
        sda_raw = 1'b1;
        wait_cyc(4);
        chk("R5 release dropped", int'(bus_release), 0);

        // R3, R10: data line stuck low alone
        wait_cyc(10);
        s0 = n_start;
        sda_raw = 1'b0; k = cyc;
        push_exp(K_ABORT, k + L*P + 1, k + (L+1)*P + 6, "R3");
        wait_cyc(10);
        chk("R10 start detected", n_start, s0 + 1);
        wait_event(K_ABORT, "R3 abort missing");
        sda_raw = 1'b1;
        wait_cyc(4);
        chk("R5 release dropped after data", int'(bus_release), 0);

        // R4: lows shorter than the limit
        a0 = n_abort;
        for (int i = 0; i < 2; i++) begin
            scl_raw = 1'b0; wait_cyc(120);
            scl_raw = 1'b1; wait_cyc(20);
        end
        wait_cyc(10);
        chk("R4 no abort for short lows", n_abort, a0);

        // R11: tick enable freeze
        tick_en = 1'b0;
        wait_cyc(5);
        scl_raw = 1'b0;
        wait_cyc(400);
        chk("R11 no abort while frozen", n_abort, a0);
        tick_en = 1'b1; k = cyc;
        push_exp(K_ABORT, k + L*P + 1, k + (L+1)*P + 6, "R11");
        wait_event(K_ABORT, "R11 abort missing");
        scl_raw = 1'b1;
        wait_cyc(4);
        chk("R5 release dropped after freeze", int'(bus_release), 0);

        // R7, R9, R10: idle re-initialization
        wait_cyc(20);
        @(posedge clk);
        keepalive = 1'b0;
        push_exp(K_REINIT, last_act + (I-1)*P, last_act + I*P + 8, "R7");
        wait_event(K_REINIT, "R7 reinit missing");
        r1 = cyc;
        push_exp(K_REINIT, r1 + (I-1)*P, r1 + I*P + 8, "R7");
        w = 0;
        while (reinit_busy === 1'b1 && w < 1000) begin
            w++;
            @(negedge clk);
        end
        chk("R9 busy width", w, B + 1);
        wait_event(K_REINIT, "R7 second reinit missing");
        sda_raw = 1'b0;
        s0 = n_start;
        wait_cyc(12);
        chk("R10 start masked while busy", n_start, s0);
        wait_cyc(100);
        sda_raw = 1'b1;
        @(posedge clk);
        keepalive = 1'b1;

        // R8: strobes and line edges keep the idle timer from expiring
        r0 = n_reinit;
        wait_cyc(3 * I * P);
        chk("R8 no reinit with strobes", n_reinit, r0);
        @(posedge clk);
        keepalive = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            scl_raw = 1'b0; wait_cyc(40);
            scl_raw = 1'b1; wait_cyc(560);
        end
        @(posedge clk);
        keepalive = 1'b1;
        wait_cyc(20);
        chk("R8 no reinit with line edges", n_reinit, r0);

        chk("R2 all expected events seen", sb_q.size(), 0);
        summary();
        $finish;
    end
endmodule